// File: doc/BRIEF.md
# Single-Channel Multi-Mode DMA Sequencer

This block is the control engine of one DMA channel. Software programs a set of configuration registers over a simple write port: a starting source address, a starting destination address, a per-address stepping rule, an offset, a transfer unit (8, 16 or 32 bits), an inner repeat/block size, a total unit count, a transfer mode, an activation source and an on-chip interrupt vector to listen for. Writing the control register with its enable bit set starts the channel; from then on the sequencer issues bus cycles on a request/acknowledge bus until the total count runs out or software clears the enable bit.

Three transfer modes share one datapath. Normal mode moves one unit per activation. Repeat mode also moves one unit per activation but returns both addresses to their programmed start values each time the inner size is used up. Block mode moves a whole inner block per activation. Each unit is either a read followed by a write (dual-address) or a single bus cycle with the device acknowledge strobe raised, where the external device takes the place of one address (single-address). A channel can be started by software alone, by a matching on-chip interrupt vector, or by an external request pin.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset the channel is inactive and drives no bus request, no device acknowledge and no done pulse.
- R2: In dual-address mode each unit is a bus read at the current source address followed by a bus write at the current destination address carrying the read data; bus_size carries the unit code (0 = byte, 1 = 16-bit, 2 = 32-bit).
- R3: After each unit every address steps according to its own 2-bit rule: 0 keeps it fixed, 1 adds the unit size in bytes (1, 2 or 4), 2 subtracts it, 3 adds the programmed offset register.
- R4: With a total count N loaded (register 3, N nonzero, limit flag clear), the channel moves exactly N units, then pulses done_irq for one cycle and becomes inactive.
- R5: With the unlimited flag (control bit 12) set, the total count is ignored: the channel keeps running until software writes the control register with enable (bit 13) clear, then goes inactive at a unit boundary without a done pulse.
- R6: In repeat mode (mode field bits 3:2 = 1) both addresses return to their programmed start values after every inner-size units.
- R7: In block mode (mode field = 2) one activation moves a full inner block of units, after which the channel waits for the next activation.
- R8: An inner size register (register 2) value of 0 stands for 65,536 units.
- R9: With vector activation (control bits 11:10 = 1), a unit starts only after irq_valid arrives with irq_vec equal to the vector select register (register 6); a select value of 0 never activates the channel.
- R10: With external activation (control bits 11:10 = 2), nothing moves until ext_req is seen; with auto activation (0) units run back to back without any request.
- R11: In single-address mode (control bit 4) each unit is one bus cycle with dack high; direction bit 5 = 0 writes at the destination address, 1 reads at the source address.
- R12: Once bus_req is raised it stays high with address and direction unchanged until bus_ack is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Register select: 0 source, 1 destination, 2 inner size, 3 total count, 4 control, 5 offset, 6 vector select |
| cfg_wdata | input | AW | Configuration write data |
| irq_valid | input | 1 | On-chip interrupt event valid |
| irq_vec | input | VW | Vector number of the interrupt event |
| ext_req | input | 1 | External transfer request |
| bus_req | output | 1 | Bus cycle request |
| bus_we | output | 1 | Bus cycle is a write |
| bus_addr | output | AW | Bus cycle address |
| bus_size | output | 2 | Unit code of the bus cycle |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data, valid with bus_ack on reads |
| bus_ack | input | 1 | Bus cycle completion |
| dack | output | 1 | Device acknowledge for single-address cycles |
| done_irq | output | 1 | One-cycle pulse when the total count expires |
| active | output | 1 | Channel is running |

## Verification
Every cycle the assertions watch the bus handshake (a request held stable until acknowledged, a write following each acknowledged dual-address read), that dack appears only on single-address channels, that done_irq is a lone pulse followed by an inactive channel, that the inner counter never sits at zero while running, and that a zero vector select never latches a request. Address sequences under each stepping rule, repeat reloads, block-per-activation grouping, the 65,536 encoding of a zero inner size, the filtering of non-matching vectors and the stop on software command depend on whole runs, so only the bench's directed scenarios, which compare the full bus log against sequences computed from the requirements, can show them.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    typedef enum logic [1:0] {
        STEP_FIX = 2'd0,
        STEP_INC = 2'd1,
        STEP_DEC = 2'd2,
        STEP_OFF = 2'd3
    } step_e;

    typedef enum logic [1:0] {
        MODE_NORM = 2'd0,
        MODE_RPT  = 2'd1,
        MODE_BLK  = 2'd2,
        MODE_RSV  = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        ACT_AUTO    = 2'd0,
        ACT_VEC     = 2'd1,
        ACT_EXT     = 2'd2,
        ACT_EXT_ALT = 2'd3
    } act_e;

    typedef enum logic [2:0] {
        ST_OFF  = 3'd0,
        ST_WAIT = 3'd1,
        ST_RD   = 3'd2,
        ST_WR   = 3'd3,
        ST_ONE  = 3'd4
    } st_e;

    // control register layout, MSB first (bits 13..0)
    typedef struct packed {
        logic       en;        // 13
        logic       unlim;     // 12
        act_e       act;       // 11:10
        step_e      dst_step;  // 9:8
        step_e      src_step;  // 7:6
        logic       sdir;      // 5
        logic       single;    // 4
        mode_e      mode;      // 3:2
        logic [1:0] unit;      // 1:0
    } ctrl_t;

    localparam logic [2:0] REG_SRC  = 3'd0;
    localparam logic [2:0] REG_DST  = 3'd1;
    localparam logic [2:0] REG_BLK  = 3'd2;
    localparam logic [2:0] REG_TOT  = 3'd3;
    localparam logic [2:0] REG_CTRL = 3'd4;
    localparam logic [2:0] REG_OFF  = 3'd5;
    localparam logic [2:0] REG_VEC  = 3'd6;

endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
    import dma_seq_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 32,
    parameter int BW = 16,
    parameter int VW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [2:0]    addr_i,
    input  logic [AW-1:0] wdata_i,
    input  logic          clr_en_i,
    output logic [AW-1:0] src_o,
    output logic [AW-1:0] dst_o,
    output logic [AW-1:0] off_o,
    output logic [CW-1:0] tot_o,
    output logic [BW-1:0] blk_o,
    output logic [VW-1:0] vec_o,
    output ctrl_t         ctrl_o,
    output logic          start_o
);

    localparam int CTW = $bits(ctrl_t);

    typedef struct packed {
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [AW-1:0] off;
        logic [CW-1:0] tot;
        logic [BW-1:0] blk;
        logic [VW-1:0] vec;
        ctrl_t         ctrl;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  ctrl_wr;

    always_comb begin
        regs_d  = regs_q;
        ctrl_wr = we_i && (addr_i == REG_CTRL);
        if (we_i) begin
            case (addr_i)
                REG_SRC:  regs_d.src  = wdata_i;
                REG_DST:  regs_d.dst  = wdata_i;
                REG_BLK:  regs_d.blk  = wdata_i[BW-1:0];
                REG_TOT:  regs_d.tot  = wdata_i[CW-1:0];
                REG_CTRL: regs_d.ctrl = ctrl_t'(wdata_i[CTW-1:0]);
                REG_OFF:  regs_d.off  = wdata_i;
                REG_VEC:  regs_d.vec  = wdata_i[VW-1:0];
                default:  regs_d      = regs_q;
            endcase
        end
        if (clr_en_i && !ctrl_wr) begin
            regs_d.ctrl.en = 1'b0;
        end
        start_o = ctrl_wr && wdata_i[CTW-1] && !regs_q.ctrl.en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign src_o  = regs_q.src;
    assign dst_o  = regs_q.dst;
    assign off_o  = regs_q.off;
    assign tot_o  = regs_q.tot;
    assign blk_o  = regs_q.blk;
    assign vec_o  = regs_q.vec;
    assign ctrl_o = regs_q.ctrl;

endmodule

// File: rtl/dma_req_gate.sv
module dma_req_gate
    import dma_seq_pkg::*;
#(
    parameter int VW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          armed_i,
    input  logic          consume_i,
    input  act_e          act_i,
    input  logic [VW-1:0] vec_sel_i,
    input  logic          irq_valid_i,
    input  logic [VW-1:0] irq_vec_i,
    input  logic          ext_req_i,
    output logic          go_o
);

    logic pend_d, pend_q;
    logic vec_hit, ext_hit;

    always_comb begin
        vec_hit = (act_i == ACT_VEC) && irq_valid_i &&
                  (irq_vec_i == vec_sel_i) && (vec_sel_i != '0);
        ext_hit = ((act_i == ACT_EXT) || (act_i == ACT_EXT_ALT)) && ext_req_i;
        pend_d  = pend_q;
        if (!armed_i) begin
            pend_d = 1'b0;
        end else begin
            if (consume_i)          pend_d = 1'b0;
            if (vec_hit || ext_hit) pend_d = 1'b1;
        end
        go_o = (act_i == ACT_AUTO) || pend_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
    end

    // R9: a zero vector select can never arm a pending request
    p_vec_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (act_i == ACT_VEC && vec_sel_i == '0 && !pend_q) |=> !pend_q);

endmodule

// File: rtl/dma_addr_step.sv
module dma_addr_step
    import dma_seq_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] addr_i,
    input  step_e         step_i,
    input  logic [1:0]    unit_i,
    input  logic [AW-1:0] off_i,
    output logic [AW-1:0] next_o
);

    logic [AW-1:0] unit_bytes;

    always_comb begin
        case (unit_i)
            2'd0:    unit_bytes = AW'(1);
            2'd1:    unit_bytes = AW'(2);
            default: unit_bytes = AW'(4);
        endcase
        case (step_i)
            STEP_INC: next_o = addr_i + unit_bytes;
            STEP_DEC: next_o = addr_i - unit_bytes;
            STEP_OFF: next_o = addr_i + off_i;
            default:  next_o = addr_i;
        endcase
    end

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
    import dma_seq_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int CW = 32,
    parameter int BW = 16,
    parameter int VW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_addr,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          irq_valid,
    input  logic [VW-1:0] irq_vec,
    input  logic          ext_req,
    output logic          bus_req,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [1:0]    bus_size,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    input  logic          bus_ack,
    output logic          dack,
    output logic          done_irq,
    output logic          active
);

    localparam int NSIDE = 2;
    localparam logic [CW:0] TOT_ONE = (CW+1)'(1);
    localparam logic [CW:0] TOT_MAX = {1'b1, {CW{1'b0}}};
    localparam logic [BW:0] BLK_ONE = (BW+1)'(1);
    localparam logic [BW:0] BLK_MAX = {1'b1, {BW{1'b0}}};

    typedef struct packed {
        st_e           st;
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [CW:0]   tot;
        logic [BW:0]   blk;
        logic [DW-1:0] data;
        logic          done;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [AW-1:0] cfg_src, cfg_dst, cfg_off;
    logic [CW-1:0] cfg_tot;
    logic [BW-1:0] cfg_blk;
    logic [VW-1:0] cfg_vec;
    ctrl_t         ctrl;
    logic          start, clr_en, consume, go;
    logic [CW:0]   tot_load;
    logic [BW:0]   blk_load;
    logic          unit_end;

    logic [AW-1:0] side_cur  [NSIDE];
    logic [AW-1:0] side_next [NSIDE];
    step_e         side_step [NSIDE];

    dma_cfg_regs #(.AW(AW), .CW(CW), .BW(BW), .VW(VW)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (cfg_we),
        .addr_i   (cfg_addr),
        .wdata_i  (cfg_wdata),
        .clr_en_i (clr_en),
        .src_o    (cfg_src),
        .dst_o    (cfg_dst),
        .off_o    (cfg_off),
        .tot_o    (cfg_tot),
        .blk_o    (cfg_blk),
        .vec_o    (cfg_vec),
        .ctrl_o   (ctrl),
        .start_o  (start)
    );

    dma_req_gate #(.VW(VW)) u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .armed_i     (seq_q.st != ST_OFF),
        .consume_i   (consume),
        .act_i       (ctrl.act),
        .vec_sel_i   (cfg_vec),
        .irq_valid_i (irq_valid),
        .irq_vec_i   (irq_vec),
        .ext_req_i   (ext_req),
        .go_o        (go)
    );

    assign side_cur[0]  = seq_q.src;
    assign side_cur[1]  = seq_q.dst;
    assign side_step[0] = ctrl.src_step;
    assign side_step[1] = ctrl.dst_step;

    for (genvar g = 0; g < NSIDE; g++) begin : g_side
        dma_addr_step #(.AW(AW)) u_step (
            .addr_i (side_cur[g]),
            .step_i (side_step[g]),
            .unit_i (ctrl.unit),
            .off_i  (cfg_off),
            .next_o (side_next[g])
        );
    end

    assign tot_load = (cfg_tot == '0) ? TOT_MAX : {1'b0, cfg_tot};
    assign blk_load = (cfg_blk == '0) ? BLK_MAX : {1'b0, cfg_blk};

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        consume    = 1'b0;
        clr_en     = 1'b0;
        unit_end   = 1'b0;

        case (seq_q.st)
            ST_OFF: begin
                if (start) begin
                    seq_d.st  = ST_WAIT;
                    seq_d.src = cfg_src;
                    seq_d.dst = cfg_dst;
                    seq_d.tot = tot_load;
                    seq_d.blk = blk_load;
                end
            end
            ST_WAIT: begin
                if (!ctrl.en) begin
                    seq_d.st = ST_OFF;
                end else if (go) begin
                    consume  = 1'b1;
                    seq_d.st = ctrl.single ? ST_ONE : ST_RD;
                end
            end
            ST_RD: begin
                if (bus_ack) begin
                    seq_d.data = bus_rdata;
                    seq_d.st   = ST_WR;
                end
            end
            ST_WR:   unit_end = bus_ack;
            ST_ONE:  unit_end = bus_ack;
            default: seq_d.st = ST_OFF;
        endcase

        if (unit_end) begin
            seq_d.src = side_next[0];
            seq_d.dst = side_next[1];
            seq_d.blk = seq_q.blk - BLK_ONE;
            if (!ctrl.unlim) begin
                seq_d.tot = seq_q.tot - TOT_ONE;
            end
            if (seq_q.blk == BLK_ONE) begin
                seq_d.blk = blk_load;
            end
            if (!ctrl.unlim && seq_q.tot == TOT_ONE) begin
                seq_d.done = 1'b1;
                clr_en     = 1'b1;
                seq_d.st   = ST_OFF;
            end else if (!ctrl.en) begin
                seq_d.st = ST_OFF;
            end else begin
                seq_d.st = ST_WAIT;
                case (ctrl.mode)
                    MODE_RPT: begin
                        if (seq_q.blk == BLK_ONE) begin
                            seq_d.src = cfg_src;
                            seq_d.dst = cfg_dst;
                        end
                    end
                    MODE_BLK: begin
                        if (seq_q.blk != BLK_ONE) begin
                            seq_d.st = ctrl.single ? ST_ONE : ST_RD;
                        end
                    end
                    default: seq_d.st = ST_WAIT;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    always_comb begin
        bus_req   = (seq_q.st == ST_RD) || (seq_q.st == ST_WR) || (seq_q.st == ST_ONE);
        bus_we    = (seq_q.st == ST_WR) || ((seq_q.st == ST_ONE) && !ctrl.sdir);
        bus_addr  = seq_q.src;
        if (seq_q.st == ST_WR || (seq_q.st == ST_ONE && !ctrl.sdir)) begin
            bus_addr = seq_q.dst;
        end
        bus_size  = ctrl.unit;
        bus_wdata = seq_q.data;
        dack      = (seq_q.st == ST_ONE);
        done_irq  = seq_q.done;
        active    = (seq_q.st != ST_OFF);
    end

    // R12: a raised request waits, unchanged, for its acknowledge
    p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));

    // R2: an acknowledged dual-address read is followed by the write
    p_rd_then_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && !dack && bus_ack) |=> (bus_req && bus_we && !dack));

    // R4: the done pulse lasts one cycle and leaves the channel stopped
    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |=> (!done_irq && !active));

    // R11: the device strobe belongs only to single-address channels
    p_dack_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        dack |-> (ctrl.single && bus_req));

    // R7: the inner counter never rests at zero while running
    p_blk_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (seq_q.blk != '0));

endmodule

// File: tb/dma_chan_seq_bench.sv
module dma_chan_seq_bench;

    localparam int CLK_PER = 10;
    localparam int LOGN    = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        irq_valid = 1'b0;
    logic [7:0]  irq_vec = '0;
    logic        ext_req = 1'b0;
    logic        bus_req, bus_we, dack, done_irq, active;
    logic [31:0] bus_addr, bus_wdata;
    logic [1:0]  bus_size;
    logic [31:0] bus_rdata = '0;
    logic        bus_ack = 1'b0;

    int checks = 0;
    int errors = 0;

    dma_chan_seq u_dma_chan_seq (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .irq_valid(irq_valid), .irq_vec(irq_vec),
        .ext_req(ext_req), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack), .dack(dack),
        .done_irq(done_irq), .active(active)
    );

    always #(CLK_PER/2) clk = ~clk;

    // bus log written by the responder
    logic [31:0] la [LOGN];
    logic [31:0] ld [LOGN];
    logic        lw [LOGN];
    logic        lk [LOGN];
    logic [1:0]  lz [LOGN];
    int          ln = 0;
    int          lat = 0;
    int          wc = 0;
    int          hold_err = 0;
    int          dcnt = 0;
    logic [31:0] hold_addr = '0;
    logic        hold_we = 1'b0;

    function automatic logic [31:0] fdat(input logic [31:0] a);
        return {a[15:0] ^ 16'hA5A5, a[15:0]};
    endfunction

    function automatic logic [31:0] nxt(input logic [31:0] a, input int st,
                                        input int unit, input logic [31:0] off);
        logic [31:0] ub;
        ub = (unit == 0) ? 32'd1 : (unit == 1) ? 32'd2 : 32'd4;
        case (st)
            1:       return a + ub;
            2:       return a - ub;
            3:       return a + off;
            default: return a;
        endcase
    endfunction

    function automatic logic [31:0] mk(input int unit, input int mode, input int single,
                                       input int sdir, input int ss, input int ds,
                                       input int act, input int unlim, input int en);
        logic [31:0] v;
        v = '0;
        v[1:0]   = unit[1:0];
        v[3:2]   = mode[1:0];
        v[4]     = single[0];
        v[5]     = sdir[0];
        v[7:6]   = ss[1:0];
        v[9:8]   = ds[1:0];
        v[11:10] = act[1:0];
        v[12]    = unlim[0];
        v[13]    = en[0];
        return v;
    endfunction

    always @(negedge clk) begin
        if (done_irq) dcnt = dcnt + 1;
        if (!rst_n) begin
            bus_ack = 1'b0;
            wc = 0;
        end else if (bus_ack) begin
            bus_ack = 1'b0;
            wc = 0;
        end else if (bus_req) begin
            if (wc == 0) begin
                hold_addr = bus_addr;
                hold_we   = bus_we;
            end else if (bus_addr != hold_addr || bus_we != hold_we) begin
                hold_err = hold_err + 1;
            end
            if (wc >= lat) begin
                bus_ack = 1'b1;
                wc = 0;
                if (!bus_we) bus_rdata = fdat(bus_addr);
                if (ln < LOGN) begin
                    la[ln] = bus_addr;
                    lw[ln] = bus_we;
                    lk[ln] = dack;
                    lz[ln] = bus_size;
                    ld[ln] = bus_we ? bus_wdata : fdat(bus_addr);
                    ln = ln + 1;
                end
            end else begin
                wc = wc + 1;
            end
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [63:0] act_v,
                       input logic [63:0] exp_v);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0h expected %0h", tag, act_v, exp_v);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_off();
        for (int i = 0; i < 5000; i++) begin
            if (!active) break;
            @(negedge clk);
        end
        idle(2);
    endtask

    task automatic setup(input logic [31:0] s, input logic [31:0] d, input logic [31:0] blk,
                         input logic [31:0] tot, input logic [31:0] off);
        wr(3'd0, s); wr(3'd1, d); wr(3'd2, blk); wr(3'd3, tot); wr(3'd5, off);
    endtask

    // compare n dual-address units starting at log index b
    task automatic check_dual(input string tag, input int b, input int n,
                              input logic [31:0] s0, input int ss,
                              input logic [31:0] d0, input int ds,
                              input int unit, input logic [31:0] off, input int rep);
        logic [31:0] s, d;
        s = s0; d = d0;
        for (int i = 0; i < n; i++) begin
            int k;
            logic ok;
            k = b + 2 * i;
            ok = (la[k] == s) && !lw[k] && !lk[k] && (lz[k] == unit[1:0]) &&
                 (la[k+1] == d) && lw[k+1] && !lk[k+1] && (ld[k+1] == fdat(s));
            chk(ok, tag, {la[k], la[k+1]}, {s, d});
            chk(ld[k+1] == fdat(s), tag, {32'd0, ld[k+1]}, {32'd0, fdat(s)});
            s = nxt(s, ss, unit, off);
            d = nxt(d, ds, unit, off);
            if (rep != 0 && ((i + 1) % rep) == 0) begin
                s = s0; d = d0;
            end
        end
    endtask

    task automatic t_reset();
        chk(!bus_req && !dack && !done_irq && !active, "R1 reset outputs",
            {60'd0, bus_req, dack, done_irq, active}, 64'd0);
    endtask

    task automatic t_normal_inc();
        int b, dc;
        b = ln; dc = dcnt; lat = 0;
        setup(32'h1000, 32'h2000, 32'd1, 32'd4, 32'd0);
        wr(3'd4, mk(1, 0, 0, 0, 1, 1, 0, 0, 1));
        wait_off();
        chk(ln - b == 8, "R2 R4 entry count", 64'(ln - b), 64'd8);
        check_dual("R2 R3 inc word", b, 4, 32'h1000, 1, 32'h2000, 1, 1, 32'd0, 0);
        chk(dcnt - dc == 1, "R4 done pulses", 64'(dcnt - dc), 64'd1);
        chk(!active, "R4 inactive after count", {63'd0, active}, 64'd0);
    endtask

    task automatic t_dec_fix_stall();
        int b, dc;
        b = ln; dc = dcnt; lat = 2; hold_err = 0;
        setup(32'h1100, 32'h2200, 32'd1, 32'd3, 32'd0);
        wr(3'd4, mk(0, 0, 0, 0, 2, 0, 0, 0, 1));
        wait_off();
        chk(ln - b == 6, "R4 entry count dec", 64'(ln - b), 64'd6);
        check_dual("R3 dec byte fixed dst", b, 3, 32'h1100, 2, 32'h2200, 0, 0, 32'd0, 0);
        chk(hold_err == 0, "R12 request held stable", 64'(hold_err), 64'd0);
        chk(dcnt - dc == 1, "R4 done pulse dec", 64'(dcnt - dc), 64'd1);
        lat = 0;
    endtask

    task automatic t_offset_long();
        int b;
        b = ln;
        setup(32'h0800, 32'h4000, 32'd1, 32'd3, 32'h0000_0010);
        wr(3'd4, mk(2, 0, 0, 0, 3, 2, 0, 0, 1));
        wait_off();
        chk(ln - b == 6, "R3 entry count offset", 64'(ln - b), 64'd6);
        check_dual("R3 offset long", b, 3, 32'h0800, 3, 32'h4000, 2, 2, 32'h10, 0);
    endtask

    task automatic t_repeat();
        int b;
        b = ln;
        setup(32'h0500, 32'h0600, 32'd2, 32'd5, 32'd0);
        wr(3'd4, mk(0, 1, 0, 0, 1, 1, 0, 0, 1));
        wait_off();
        chk(ln - b == 10, "R6 entry count", 64'(ln - b), 64'd10);
        check_dual("R6 repeat reload", b, 5, 32'h0500, 1, 32'h0600, 1, 0, 32'd0, 2);
    endtask

    task automatic t_size_zero();
        int b;
        b = ln;
        setup(32'h0700, 32'h0900, 32'd0, 32'd20, 32'd0);
        wr(3'd4, mk(0, 1, 0, 0, 1, 1, 0, 0, 1));
        wait_off();
        chk(ln - b == 40, "R8 entry count", 64'(ln - b), 64'd40);
        check_dual("R8 zero size no early reload", b, 20, 32'h0700, 1, 32'h0900, 1, 0, 32'd0, 0);
    endtask

    task automatic t_block_ext();
        int b, dc;
        b = ln; dc = dcnt;
        setup(32'h0A00, 32'h0B00, 32'd3, 32'd6, 32'd0);
        wr(3'd4, mk(0, 2, 0, 0, 1, 1, 2, 0, 1));
        idle(20);
        chk(ln == b && active, "R10 no external request yet", 64'(ln - b), 64'd0);
        @(negedge clk); ext_req = 1'b1; @(negedge clk); ext_req = 1'b0;
        idle(40);
        chk(ln - b == 6 && active, "R7 one block per request", 64'(ln - b), 64'd6);
        @(negedge clk); ext_req = 1'b1; @(negedge clk); ext_req = 1'b0;
        wait_off();
        chk(ln - b == 12, "R7 second block", 64'(ln - b), 64'd12);
        check_dual("R7 block addresses", b, 6, 32'h0A00, 1, 32'h0B00, 1, 0, 32'd0, 0);
        chk(dcnt - dc == 1, "R4 block done", 64'(dcnt - dc), 64'd1);
    endtask

    task automatic t_vector();
        int b, dc;
        b = ln;
        setup(32'h0C00, 32'h0D00, 32'd1, 32'd2, 32'd0);
        wr(3'd6, 32'h21);
        wr(3'd4, mk(0, 0, 0, 0, 1, 1, 1, 0, 1));
        @(negedge clk); irq_valid = 1'b1; irq_vec = 8'h20; @(negedge clk); irq_valid = 1'b0;
        idle(20);
        chk(ln == b, "R9 other vector ignored", 64'(ln - b), 64'd0);
        @(negedge clk); irq_valid = 1'b1; irq_vec = 8'h21; @(negedge clk); irq_valid = 1'b0;
        idle(20);
        chk(ln - b == 2 && active, "R9 matching vector one unit", 64'(ln - b), 64'd2);
        @(negedge clk); irq_valid = 1'b1; @(negedge clk); irq_valid = 1'b0;
        wait_off();
        check_dual("R9 vector addresses", b, 2, 32'h0C00, 1, 32'h0D00, 1, 0, 32'd0, 0);
        // zero select never activates
        b = ln; dc = dcnt;
        wr(3'd6, 32'h0);
        wr(3'd4, mk(0, 0, 0, 0, 1, 1, 1, 0, 1));
        @(negedge clk); irq_valid = 1'b1; irq_vec = 8'h00; @(negedge clk); irq_valid = 1'b0;
        idle(20);
        chk(ln == b && active, "R9 zero select ignored", 64'(ln - b), 64'd0);
        wr(3'd4, mk(0, 0, 0, 0, 1, 1, 1, 0, 0));
        wait_off();
        chk(!active && dcnt == dc, "R5 software stop while waiting", {63'd0, active}, 64'd0);
    endtask

    task automatic t_single();
        int b;
        b = ln;
        setup(32'h0, 32'h3000, 32'd1, 32'd2, 32'd0);
        wr(3'd4, mk(2, 0, 1, 0, 0, 1, 0, 0, 1));
        wait_off();
        chk(ln - b == 2, "R11 one cycle per unit", 64'(ln - b), 64'd2);
        chk(la[b] == 32'h3000 && lw[b] && lk[b], "R11 dev to mem unit 0", {32'd0, la[b]}, 64'h3000);
        chk(la[b+1] == 32'h3004 && lw[b+1] && lk[b+1], "R11 dev to mem unit 1",
            {32'd0, la[b+1]}, 64'h3004);
        b = ln;
        setup(32'h4000, 32'h0, 32'd1, 32'd2, 32'd0);
        wr(3'd4, mk(1, 0, 1, 1, 2, 0, 0, 0, 1));
        wait_off();
        chk(ln - b == 2, "R11 mem to dev count", 64'(ln - b), 64'd2);
        chk(la[b] == 32'h4000 && !lw[b] && lk[b], "R11 mem to dev unit 0", {32'd0, la[b]}, 64'h4000);
        chk(la[b+1] == 32'h3FFE && !lw[b+1] && lk[b+1], "R11 mem to dev unit 1",
            {32'd0, la[b+1]}, 64'h3FFE);
    endtask

    task automatic t_unlimited();
        int b, dc;
        b = ln; dc = dcnt;
        setup(32'h0E00, 32'h0F00, 32'd1, 32'd1, 32'd0);
        wr(3'd4, mk(0, 0, 0, 0, 0, 1, 0, 1, 1));
        idle(80);
        chk(active, "R5 runs past total count", {63'd0, active}, 64'd1);
        wr(3'd4, mk(0, 0, 0, 0, 0, 1, 0, 1, 0));
        wait_off();
        chk(!active, "R5 stops on software write", {63'd0, active}, 64'd0);
        chk(dcnt == dc, "R5 no done pulse", 64'(dcnt - dc), 64'd0);
        chk(((ln - b) % 2) == 0 && (ln - b) > 8, "R5 whole units moved", 64'(ln - b), 64'd10);
        check_dual("R5 fixed src inc dst", b, (ln - b) / 2, 32'h0E00, 0, 32'h0F00, 1, 0, 32'd0, 0);
    endtask

    initial begin
        #(CLK_PER * 150000);
        errors = errors + 1;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        idle(2);
        t_reset();
        t_normal_inc();
        t_dec_fix_stall();
        t_offset_long();
        t_repeat();
        t_size_zero();
        t_block_ext();
        t_vector();
        t_single();
        t_unlimited();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule